// File: doc/BRIEF.md
# Multiplexed Video Memory Decoder

This block answers a 14-bit video address space over a multiplexed bus. The low address byte travels on the same eight lines as the data, and the upper six address bits come on lines of their own. An access has two phases. In the address phase the latch strobe is high and the full address is on the bus. In the data phase the latch strobe is low and a read or write strobe, both active low, moves one byte.

The address space is split by the upper bits into three regions. The lower half holds a computed pattern ROM. The page with all upper bits set holds a 32-byte palette RAM. Every other address in the upper half maps into a 2 KiB name-table RAM, with bit 10 choosing one of two tables and bit 11 ignored. The shared lines are modelled as a separate input (`ad_in`), output (`ad_out`) and output enable (`ad_oe`), so they fit an FPGA pad or an external tristate buffer.

Top module: `vmem_decoder`

## Requirements
- R1: A synchronous active-high `rst` forces `ad_oe` low at the next clock edge, even in the middle of a read data phase.
- R2: On every rising edge where `ale` is 1, the block captures `ad_in` as address bits 7:0 and `addr_hi` as bits 13:8. While `ale` is 0, the held address does not change, whatever `ad_in` and `addr_hi` do; when `ale` is high for several edges, the last one wins.
- R3: A rising edge with `ale`=0 and `rd_n`=0 sets `ad_oe` to 1 from that edge on, with `ad_out` carrying the byte at the held address.
- R4: `ad_oe` is 1 only after an edge where `ale`=0 and `rd_n`=0. An edge with `rd_n`=1, or with `ale`=1, clears it, so the lines are released during write phases and address phases. `ad_out` is 0 while `ad_oe` is 0.
- R5: Addresses 0x0000–0x1FFF (bit 13 = 0) read the pattern ROM. The byte at address a is a[7:0] XOR ((a[12:8] × 37) mod 256).
- R6: A write in the pattern region changes nothing; a later read returns the R5 value.
- R7: Addresses with bit 13 = 1 and bits 13:8 not equal to 0x3F are name-table RAM. A write with `ale`=0 and `wr_n`=0 stores `ad_in` there, and a read returns it.
- R8: The name-table index is address bits 10:0. So 0x2800 aliases 0x2000, 0x2400 is a distinct table, and 0x3000–0x3EFF repeat the same 2 KiB.
- R9: Addresses 0x3F00–0x3FFF are palette RAM indexed by bits 4:0. So 0x3FE0 aliases 0x3F00, and 0x3FF0+i aliases 0x3F10+i.
- R10: Palette and name-table storage are separate. Writing the palette page leaves the name-table byte at the same bits 10:0 (for example 0x2700 against 0x3F00) unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch strobe, high during the address phase |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr_hi | input | 6 | Address bits 13:8 |
| ad_in | input | 8 | Shared lines as seen by the block (low address byte or write data) |
| ad_out | output | 8 | Read data driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines; 0 means released |

## Verification
The hardest case to reach from the ports is showing that the held address is truly frozen during the data phase. A read that happens to return the right byte proves nothing if the bus still carries the address. To rule that out, every read task replaces `ad_in` with an unrelated byte and inverts `addr_hi` as soon as `ale` falls, so a decoder that looked at the live lines would return the wrong byte. The latch scenario also holds `ale` high across two different addresses, so that only the last one may be used.

// File: rtl/vmem_pkg.sv
package vmem_pkg;

  // Region selected by the upper address bits.
  typedef enum logic [1:0] {
    RG_PATTERN = 2'd0,
    RG_NAMETBL = 2'd1,
    RG_PALETTE = 2'd2
  } vregion_e;

endpackage

// File: rtl/vmem_addr_latch.sv
// Holds the access address; follows the bus on every edge while ale is high.
module vmem_addr_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale,
  input  logic [LO_W-1:0] lo_in,
  input  logic [HI_W-1:0] hi_in,
  output logic [LO_W-1:0] lo_q,
  output logic [HI_W-1:0] hi_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (ale) begin
      lo_q <= lo_in;
      hi_q <= hi_in;
    end
  end

endmodule

// File: rtl/vmem_region_decode.sv
// Upper bits pick the region: MSB clear -> pattern, all ones -> palette.
module vmem_region_decode
  import vmem_pkg::*;
#(
  parameter int HI_W = 6
) (
  input  logic [HI_W-1:0] hi,
  output vregion_e        region
);

  always_comb begin
    if (!hi[HI_W-1])
      region = RG_PATTERN;
    else if (&hi)
      region = RG_PALETTE;
    else
      region = RG_NAMETBL;
  end

endmodule

// File: rtl/vmem_pattern_rom.sv
// Computed read-only pattern content with a registered output.
module vmem_pattern_rom #(
  parameter int DW   = 8,
  parameter int SELW = 5
) (
  input  logic            clk,
  input  logic [DW-1:0]   lo,
  input  logic [SELW-1:0] sel,
  output logic [DW-1:0]   rdata
);

  localparam logic [DW-1:0] SCRAMBLE = DW'(37);

  logic [DW-1:0] mix;

  always_comb mix = DW'(sel) * SCRAMBLE;

  always_ff @(posedge clk) rdata <= lo ^ mix;

endmodule

// File: rtl/vmem_ram.sv
// Single-port RAM with a synchronous read that returns the old data.
module vmem_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/vmem_decoder.sv
module vmem_decoder
  import vmem_pkg::*;
#(
  parameter int DW     = 8,
  parameter int HI_W   = 6,
  parameter int NT_AW  = 11,
  parameter int PAL_AW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [HI_W-1:0] addr_hi,
  input  logic [DW-1:0]   ad_in,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe
);

  localparam int AW_TOT = DW + HI_W;

  logic [DW-1:0]     lat_lo;
  logic [HI_W-1:0]   lat_hi;
  vregion_e          region;
  vregion_e          rsel_q;
  logic              oe_q;
  logic              rd_act;
  logic              wr_act;
  logic [NT_AW-1:0]  nt_idx;
  logic [PAL_AW-1:0] pal_idx;
  logic [DW-1:0]     rom_q;
  logic [DW-1:0]     nt_q;
  logic [DW-1:0]     pal_q;

  vmem_addr_latch #(.LO_W(DW), .HI_W(HI_W)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .ale   (ale),
    .lo_in (ad_in),
    .hi_in (addr_hi),
    .lo_q  (lat_lo),
    .hi_q  (lat_hi)
  );

  vmem_region_decode #(.HI_W(HI_W)) u_dec (
    .hi     (lat_hi),
    .region (region)
  );

  always_comb begin
    rd_act  = !rd_n && !ale;
    wr_act  = !wr_n && !ale;
    nt_idx  = NT_AW'({lat_hi, lat_lo});
    pal_idx = PAL_AW'(lat_lo);
  end

  vmem_pattern_rom #(.DW(DW), .SELW(HI_W-1)) u_rom (
    .clk   (clk),
    .lo    (lat_lo),
    .sel   (lat_hi[HI_W-2:0]),
    .rdata (rom_q)
  );

  vmem_ram #(.AW(NT_AW), .DW(DW)) u_nametbl (
    .clk   (clk),
    .we    (wr_act && region == RG_NAMETBL),
    .addr  (nt_idx),
    .wdata (ad_in),
    .rdata (nt_q)
  );

  vmem_ram #(.AW(PAL_AW), .DW(DW)) u_palette (
    .clk   (clk),
    .we    (wr_act && region == RG_PALETTE),
    .addr  (pal_idx),
    .wdata (ad_in),
    .rdata (pal_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      rsel_q <= RG_PATTERN;
    end else begin
      oe_q   <= rd_act;
      rsel_q <= region;
    end
  end

  always_comb begin
    ad_out = '0;
    if (oe_q) begin
      case (rsel_q)
        RG_NAMETBL: ad_out = nt_q;
        RG_PALETTE: ad_out = pal_q;
        default:    ad_out = rom_q;
      endcase
    end
    ad_oe = oe_q;
  end

  initial begin
    if (NT_AW > AW_TOT - 2) $error("name-table index wider than region");
    if (PAL_AW > DW) $error("palette index wider than low byte");
  end

endmodule

// File: rtl/vmem_decoder_chk.sv
module vmem_decoder_chk #(
  parameter int DW   = 8,
  parameter int HI_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            ale,
  input logic            rd_n,
  input logic [HI_W-1:0] addr_hi,
  input logic [DW-1:0]   ad_in,
  input logic            ad_oe,
  input logic [DW-1:0]   lat_lo,
  input logic [HI_W-1:0] lat_hi
);

  p_reset_release_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !ad_oe);

  p_latch_capture_r2: assert property (@(posedge clk) disable iff (rst)
    ale |=> (lat_lo == $past(ad_in)) && (lat_hi == $past(addr_hi)));

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(lat_lo) && $stable(lat_hi));

  p_drive_on_read_r3: assert property (@(posedge clk) disable iff (rst)
    (!ale && !rd_n) |=> ad_oe);

  p_drive_source_r4: assert property (@(posedge clk) disable iff (rst)
    (ale || rd_n) |=> !ad_oe);

endmodule

bind vmem_decoder vmem_decoder_chk #(.DW(DW), .HI_W(HI_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ale     (ale),
  .rd_n    (rd_n),
  .addr_hi (addr_hi),
  .ad_in   (ad_in),
  .ad_oe   (ad_oe),
  .lat_lo  (lat_lo),
  .lat_hi  (lat_hi)
);

// File: tb/vmem_decoder_tb.sv
module vmem_decoder_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       ale;
  logic       rd_n;
  logic       wr_n;
  logic [5:0] addr_hi;
  logic [7:0] ad_in;
  logic [7:0] ad_out;
  logic       ad_oe;

  int checks = 0;
  int errors = 0;

  vmem_decoder u_dut (
    .clk     (clk),
    .rst     (rst),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr_hi (addr_hi),
    .ad_in   (ad_in),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] rom_val(input logic [13:0] a);
    logic [7:0] m;
    m = 8'((32'(a[12:8]) * 37) % 256);
    return a[7:0] ^ m;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    ale = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr_hi = a[13:8]; ad_in = a[7:0];
    @(negedge clk);
    ale = 1'b0; wr_n = 1'b0; ad_in = d;
    @(negedge clk);
    wr_n = 1'b1; ad_in = 8'h00;
  endtask

  // Read with the bus scrambled during the data phase; checks data and drive.
  task automatic read_chk(input logic [13:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    ale = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr_hi = a[13:8]; ad_in = a[7:0];
    @(negedge clk);
    ale = 1'b0; rd_n = 1'b0;
    ad_in = ~a[7:0] ^ 8'h5A; addr_hi = ~a[13:8];
    @(negedge clk);
    chk(req, ad_out, exp);
    chk("R3 drive during read", {7'd0, ad_oe}, 8'd1);
    rd_n = 1'b1;
    @(negedge clk);
    chk("R4 release after read", {7'd0, ad_oe}, 8'd0);
    chk("R4 zero output when released", ad_out, 8'h00);
  endtask

  task automatic t_reset;
    rst = 1'b1; ale = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    addr_hi = '0; ad_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {7'd0, ad_oe}, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    ale = 1'b1; addr_hi = 6'h01; ad_in = 8'h10;
    @(negedge clk);
    ale = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    chk("R3 drive before reset", {7'd0, ad_oe}, 8'd1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset in read phase", {7'd0, ad_oe}, 8'd0);
    rst = 1'b0; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_latch;
    @(negedge clk);
    ale = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr_hi = 6'h00; ad_in = 8'h00;
    @(negedge clk);
    addr_hi = 6'h01; ad_in = 8'h23;
    @(negedge clk);
    ale = 1'b0; rd_n = 1'b0; addr_hi = 6'h1E; ad_in = 8'hFF;
    @(negedge clk);
    chk("R2 last address wins, bus ignored", ad_out, rom_val(14'h0123));
    ad_in = 8'h00; addr_hi = 6'h00;
    @(negedge clk);
    chk("R2 held across long read", ad_out, rom_val(14'h0123));
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_release;
    @(negedge clk);
    ale = 1'b1; rd_n = 1'b0; addr_hi = 6'h08; ad_in = 8'h00;
    @(negedge clk);
    chk("R4 no drive in address phase", {7'd0, ad_oe}, 8'd0);
    ale = 1'b0; rd_n = 1'b1; wr_n = 1'b0; ad_in = 8'h3C;
    @(negedge clk);
    chk("R4 no drive in write phase", {7'd0, ad_oe}, 8'd0);
    wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_rom;
    read_chk(14'h0000, rom_val(14'h0000), "R5 rom 0x0000");
    read_chk(14'h0123, rom_val(14'h0123), "R5 rom 0x0123");
    read_chk(14'h0FA5, rom_val(14'h0FA5), "R5 rom 0x0FA5");
    read_chk(14'h1FFF, 8'h84, "R5 rom 0x1FFF");
  endtask

  task automatic t_rom_write;
    do_write(14'h0123, 8'hEE);
    do_write(14'h1FFF, 8'h00);
    read_chk(14'h0123, rom_val(14'h0123), "R6 rom write ignored 0x0123");
    read_chk(14'h1FFF, 8'h84, "R6 rom write ignored 0x1FFF");
  endtask

  task automatic t_nametbl;
    do_write(14'h2000, 8'h11);
    do_write(14'h2005, 8'h22);
    do_write(14'h27FF, 8'h33);
    do_write(14'h2700, 8'h77);
    read_chk(14'h2000, 8'h11, "R7 nametable 0x2000");
    read_chk(14'h2005, 8'h22, "R7 nametable 0x2005");
    read_chk(14'h27FF, 8'h33, "R7 nametable 0x27FF");
  endtask

  task automatic t_mirror;
    read_chk(14'h2805, 8'h22, "R8 bit 11 ignored 0x2805");
    do_write(14'h2405, 8'h44);
    read_chk(14'h2005, 8'h22, "R8 table 1 separate from table 0");
    read_chk(14'h2C05, 8'h44, "R8 mirror 0x2C05");
    read_chk(14'h3005, 8'h22, "R8 repeat 0x3005");
    read_chk(14'h3C05, 8'h44, "R8 repeat 0x3C05");
  endtask

  task automatic t_palette;
    do_write(14'h3F00, 8'h0A);
    do_write(14'h3F15, 8'h1B);
    read_chk(14'h3FE0, 8'h0A, "R9 palette 0x3FE0 alias");
    read_chk(14'h3FF5, 8'h1B, "R9 palette 0x3FF5 alias");
    read_chk(14'h3F35, 8'h1B, "R9 palette 0x3F35 alias");
    do_write(14'h3FF0, 8'h2C);
    read_chk(14'h3F10, 8'h2C, "R9 palette write via 0x3FF0");
  endtask

  task automatic t_separate;
    read_chk(14'h2700, 8'h77, "R10 nametable kept after palette writes");
    read_chk(14'h3F00, 8'h0A, "R10 palette kept");
  endtask

  initial begin
    t_reset();
    t_latch();
    t_release();
    t_rom();
    t_rom_write();
    t_nametbl();
    t_mirror();
    t_palette();
    t_separate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule